// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single data line and hands each finished character to the surrounding logic through a one-deep receive buffer. The line is resynchronised to the core clock and then sampled at sixteen times the bit rate. A start bit is only accepted if it is still low at the middle of its bit period. The character is shifted into a working register, LSB first. The data length, the parity mode and the number of stop bits are set at run time through static configuration inputs.

When the last stop bit has been sampled, the character moves from the working register into the buffer. The buffer-full status is set and a single-cycle receive interrupt is raised. The framing and parity flags are loaded at that moment. If a new frame gets close to its end while the buffer still holds an unread character, the block raises an overrun. The buffer then keeps its old contents. An error-sum output combines all three error flags. A request-to-send output tells the far end whether the receiver can accept another character.

Top module: `uart_rx_core`

## Requirements
- R1: No frame is received while `rx_en` is 0. Dropping `rx_en` returns the receiver to idle, and no `rx_irq` follows.
- R2: A falling edge on the line counts as a start bit only if the synchronised line is still low at the mid-bit sample (the 8th oversampling tick). A shorter low pulse leaves the buffer and the interrupt untouched.
- R3: `char_len` selects the data length: 00 for 7 bits, 01 for 8 bits, 10 for 9 bits, and 11 also for 8 bits. Data arrives LSB first. `rx_data` holds the character in its low bits and zeros above them.
- R4: With `par_en`=1, a parity bit follows the data. `par_odd`=1 expects an odd total count of ones over data plus parity, and `par_odd`=0 expects an even count. A mismatch sets `par_err` at the transfer.
- R5: `stop2`=0 checks one stop bit and `stop2`=1 checks two. If any checked stop bit is sampled low, `frm_err` is set at the transfer.
- R6: At the mid-sample of the last stop bit, a frame that has no overrun is written to `rx_data`. In the same clock edge `rx_full` is set, `frm_err`/`par_err` are loaded with that frame's status, and `rx_irq` pulses high for exactly one cycle.
- R7: If `rx_full` is still 1 when the bit just before the last stop bit of a frame completes, `ovr_err` is set. That frame is then dropped: `rx_data` keeps the previous character and no `rx_irq` is raised.
- R8: `err_sum` is 1 whenever any of `ovr_err`, `frm_err` or `par_err` is 1.
- R9: A `rd_strobe` pulse clears `rx_full`. An `err_clr` pulse or `rx_en`=0 clears all three error flags on the next edge.
- R10: With `rts_en`=1, `rts_n` is 0 when `rx_en`=1 and the buffer is empty, and 1 otherwise. With `rts_en`=0, `rts_n` is held at 0.
- R11: The oversampling tick occurs once every `baud_div`+1 clocks, so one bit lasts 16×(`baud_div`+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial data line, idles high |
| baud_div | input | DIV_W | Oversampling divider; tick every baud_div+1 clocks |
| char_len | input | 2 | Data length select |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop2 | input | 1 | Check two stop bits |
| rts_en | input | 1 | Enable request-to-send handshake |
| rd_strobe | input | 1 | Buffer read pulse, clears buffer-full |
| err_clr | input | 1 | Clears the error flags |
| rx_data | output | 9 | Receive buffer contents |
| rx_full | output | 1 | Buffer holds an unread character |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |
| rx_irq | output | 1 | One-cycle pulse on each buffer load |
| rts_n | output | 1 | Request to send, active low |

## Verification
The bench sends a low glitch shorter than half a bit. A receiver that trusts the falling edge alone would assemble a phantom character and raise an interrupt the scoreboard never expected. A second frame is sent while the first is still unread. A design that overwrote the buffer on overrun, or that still pulsed the interrupt, shows a changed `rx_data` or an unmatched scoreboard item. The bench also corrupts only the second of two stop bits and flips the parity bit in both odd and even modes. A design that checks just one stop bit, or that inverts the parity sense, misreports the flags that the monitor compares at each transfer. Frames sent with receive disabled, or at a second divider setting, expose a design that ignores `rx_en` or gets the bit time wrong.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rxd,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [1:0]       char_len,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             stop2,
  input  logic             rts_en,
  input  logic             rd_strobe,
  input  logic             err_clr,
  output logic [8:0]       rx_data,
  output logic             rx_full,
  output logic             ovr_err,
  output logic             frm_err,
  output logic             par_err,
  output logic             err_sum,
  output logic             rx_irq,
  output logic             rts_n
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_cnt;
  logic [1:0]       rx_sync;
  logic [3:0]       os, bit_idx, nbits;
  logic [8:0]       shreg;
  logic             par_bit, stop_bad, ovr_frame;
  logic             tick, rx_s, mid, last, pre_last, xfer, perr;

  assign tick  = rx_en && (div_cnt == baud_div);
  assign rx_s  = rx_sync[1];
  assign mid   = tick && (os == 4'd7);
  assign last  = tick && (os == 4'd15);
  assign nbits = (char_len == 2'd0) ? 4'd7 : (char_len == 2'd2) ? 4'd9 : 4'd8;

  assign pre_last = last && (
      (st == S_DATA && bit_idx == nbits && !par_en && !stop2) ||
      (st == S_PAR  && !stop2) ||
      (st == S_STOP && stop2 && bit_idx == 4'd1));

  assign xfer  = mid && (st == S_STOP) && (bit_idx == {3'b0, stop2});
  assign perr  = par_en && ((^shreg ^ par_bit) != par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      rx_sync <= 2'b11;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      if (!rx_en || div_cnt == baud_div) div_cnt <= '0;
      else                               div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      os        <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      stop_bad  <= 1'b0;
      ovr_frame <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE;
      os <= '0;
    end else if (tick) begin
      if (st == S_IDLE) begin
        if (!rx_s) begin
          st        <= S_START;
          os        <= '0;
          bit_idx   <= '0;
          shreg     <= '0;
          stop_bad  <= 1'b0;
          ovr_frame <= 1'b0;
        end
      end else begin
        os <= os + 1'b1;
        if (pre_last && rx_full) ovr_frame <= 1'b1;
        case (st)
          S_START: begin
            if (os == 4'd7 && rx_s) st <= S_IDLE;
            if (os == 4'd15) begin
              st      <= S_DATA;
              bit_idx <= '0;
            end
          end
          S_DATA: begin
            if (os == 4'd7) begin
              shreg[bit_idx] <= rx_s;
              bit_idx        <= bit_idx + 1'b1;
            end
            if (os == 4'd15 && bit_idx == nbits) begin
              st      <= par_en ? S_PAR : S_STOP;
              bit_idx <= '0;
            end
          end
          S_PAR: begin
            if (os == 4'd7) par_bit <= rx_s;
            if (os == 4'd15) begin
              st      <= S_STOP;
              bit_idx <= '0;
            end
          end
          S_STOP: begin
            if (os == 4'd7) begin
              if (!rx_s) stop_bad <= 1'b1;
              if (xfer) st <= S_IDLE;
              else      bit_idx <= bit_idx + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      ovr_err <= 1'b0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
      rx_irq  <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (rd_strobe) rx_full <= 1'b0;
      if (pre_last && rx_full) ovr_err <= 1'b1;
      if (xfer && !ovr_frame) begin
        rx_data <= shreg;
        rx_full <= 1'b1;
        frm_err <= stop_bad || !rx_s;
        par_err <= perr;
        rx_irq  <= 1'b1;
      end
      if (err_clr || !rx_en) begin
        ovr_err <= 1'b0;
        frm_err <= 1'b0;
        par_err <= 1'b0;
      end
    end
  end

  assign err_sum = ovr_err | frm_err | par_err;
  assign rts_n   = rts_en ? !(rx_en && !rx_full) : 1'b0;

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R6
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq |-> $stable(rx_data));

  // R7
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(rx_full));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr || !rx_en) |=> !err_sum);

  // R1
  dis_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_irq);

endmodule

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, rxd = 1'b1;
  logic [7:0] baud_div = 8'd1;
  logic [1:0] char_len = 2'd1;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic       rts_en = 1'b1, rd_strobe = 1'b0, err_clr = 1'b0;
  logic [8:0] rx_data;
  logic       rx_full, ovr_err, frm_err, par_err, err_sum, rx_irq, rts_n;

  int checks = 0, failures = 0;
  bit auto_rd = 1'b1;
  int irq_cnt = 0;

  typedef struct { logic [8:0] d; logic f; logic p; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  uart_rx_core uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (16 * (int'(baud_div) + 1)) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int len, input bit pen, input bit podd,
                      input bit s2, input bit bad1, input bit bad2, input bit flip,
                      input bit push, input string tag);
    logic [8:0] m;
    logic pb;
    exp_t e;
    m = d & 9'((1 << len) - 1);
    pb = podd ? ~^m : ^m;
    if (flip) pb = ~pb;
    char_len = (len == 7) ? 2'd0 : (len == 9) ? 2'd2 : 2'd1;
    par_en = pen; par_odd = podd; stop2 = s2;
    if (push) begin
      e.d = m; e.f = bad1 | (s2 & bad2); e.p = pen & flip; e.tag = tag;
      q.push_back(e);
    end
    bit_time(1'b0);
    for (int i = 0; i < len; i++) bit_time(m[i]);
    if (pen) bit_time(pb);
    bit_time(!bad1);
    if (s2) bit_time(!bad2);
    bit_time(1'b1);
    bit_time(1'b1);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rx_irq) begin
        irq_cnt++;
        if (q.size() == 0) begin
          chk(0, "R6 unexpected rx_irq", int'(rx_data), 0);
        end else begin
          e = q.pop_front();
          chk(rx_data == e.d, {e.tag, " data"}, int'(rx_data), int'(e.d));
          chk(frm_err == e.f, {e.tag, " R5 frm_err"}, int'(frm_err), int'(e.f));
          chk(par_err == e.p, {e.tag, " R4 par_err"}, int'(par_err), int'(e.p));
        end
        @(negedge clk);
        chk(rx_irq == 1'b0, "R6 irq single cycle", int'(rx_irq), 0);
        if (auto_rd) begin
          rd_strobe = 1'b1;
          @(negedge clk);
          rd_strobe = 1'b0;
        end
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(rx_full == 0 && err_sum == 0 && rx_irq == 0, "R6 reset state", int'(rx_full), 0);
    chk(rts_n == 1'b1, "R10 rts high when disabled", int'(rts_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(rts_n == 1'b0, "R10 rts low when empty", int'(rts_n), 0);

    send(9'h0A5, 8, 0, 0, 0, 0, 0, 0, 1, "R3 8N1 a5");
    send(9'h03C, 8, 0, 0, 0, 0, 0, 0, 1, "R3 8N1 3c");
    send(9'h1D5, 7, 1, 0, 0, 0, 0, 0, 1, "R3 R4 7E1");
    send(9'h1A3, 9, 1, 1, 0, 0, 0, 0, 1, "R3 R4 9O1");
    send(9'h0F0, 8, 1, 0, 0, 0, 0, 1, 1, "R4 even bad");
    send(9'h00E, 8, 1, 1, 0, 0, 0, 1, 1, "R4 odd bad");
    chk(err_sum == 1'b1, "R8 err_sum on parity", int'(err_sum), 1);
    send(9'h055, 8, 0, 0, 1, 0, 1, 0, 1, "R5 second stop low");
    send(9'h0AA, 8, 0, 0, 1, 0, 0, 0, 1, "R5 two stops ok");
    send(9'h081, 8, 0, 0, 0, 1, 0, 0, 1, "R5 one stop low");
    chk(err_sum == 1'b1, "R8 err_sum on framing", int'(err_sum), 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    chk(frm_err == 0 && err_sum == 0, "R9 err_clr clears", int'(err_sum), 0);

    n = irq_cnt;
    rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (400) @(negedge clk);
    chk(irq_cnt == n && rx_full == 0, "R2 glitch rejected", irq_cnt - n, 0);

    send(9'h0F3, 8, 1, 0, 0, 0, 0, 1, 1, "R4 before disable");
    rx_en = 1'b0; repeat (2) @(negedge clk);
    chk(err_sum == 1'b0, "R9 disable clears flags", int'(err_sum), 0);
    n = irq_cnt;
    send(9'h066, 8, 0, 0, 0, 0, 0, 0, 0, "R1 disabled");
    chk(irq_cnt == n && rx_full == 0, "R1 no reception when disabled", irq_cnt - n, 0);
    rx_en = 1'b1; repeat (2) @(negedge clk);

    auto_rd = 1'b0;
    send(9'h011, 8, 0, 0, 0, 0, 0, 0, 1, "R7 first");
    chk(rx_full == 1'b1, "R6 full after transfer", int'(rx_full), 1);
    chk(rts_n == 1'b1, "R10 rts high when full", int'(rts_n), 1);
    n = irq_cnt;
    send(9'h022, 8, 0, 0, 0, 0, 0, 0, 0, "R7 overrun");
    chk(ovr_err == 1'b1, "R7 overrun flagged", int'(ovr_err), 1);
    chk(rx_data == 9'h011, "R7 buffer kept", int'(rx_data), 'h11);
    chk(irq_cnt == n, "R7 no irq on overrun", irq_cnt - n, 0);
    chk(err_sum == 1'b1, "R8 err_sum on overrun", int'(err_sum), 1);
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
    chk(rx_full == 1'b0, "R9 read clears full", int'(rx_full), 0);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    chk(ovr_err == 1'b0, "R9 err_clr clears overrun", int'(ovr_err), 0);
    auto_rd = 1'b1;

    rts_en = 1'b0; @(negedge clk);
    chk(rts_n == 1'b0, "R10 rts held low when off", int'(rts_n), 0);
    rts_en = 1'b1;

    baud_div = 8'd3;
    send(9'h096, 8, 0, 0, 0, 0, 0, 0, 1, "R11 div3");
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R6 all frames delivered", q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule